// File: doc/BRIEF.md
# Write-Back Data Cache with Eviction Queue

This block is a small fully associative data cache that keeps stores local. A load or store is accepted over a simple request port. A hit completes with a response one cycle later. A miss fetches the whole line from memory and installs it. Load misses and store misses follow the same path: a store miss allocates the line and then merges its byte. Every line has a valid flag and a dirty flag. A store sets the dirty flag and creates no memory traffic.

When a miss has to displace a line, the victim is the first empty line, or the least recently used line when all lines are full. A clean victim is simply overwritten. A dirty victim is copied, tag and whole line, into a short first-in first-out eviction queue, and the fill goes ahead at once. The queue offers its oldest entry to memory as a full-line write and drops that entry when memory signals completion. If a miss asks for a line that is still waiting in the queue, the data comes from the newest matching queue entry instead of from memory, so stale data is never returned.

Hit and miss counters are available as outputs.

Top module: `wbc_top`

## Requirements
- R1: After reset, no line is valid, the eviction queue is empty, both counters read zero, no memory request is raised, no response is pending, and `req_ready` is 1.
- R2: A load miss raises `mem_rd_req` with the line tag (address bits [4:1]) held steady until `mem_rd_valid`. It installs the returned line as clean and returns the addressed byte with `resp_hit`=0. Byte b of a line occupies line bits [8b+7:8b].
- R3: A load hit returns the addressed byte with `resp_hit`=1 in the cycle after acceptance.
- R4: A store hit updates only the cached byte and marks the line dirty. It causes no memory write, and later loads return the stored byte.
- R5: A store miss allocates the line from memory, merges the stored byte, marks the line dirty and responds with `resp_hit`=0.
- R6: A miss fills an invalid line when one exists; otherwise it replaces the least recently used line, where both hits and fills count as uses.
- R7: Replacing a clean line produces no memory write.
- R8: Replacing a dirty line queues its tag and whole line. The queue presents its oldest entry on `mem_wr_req`/`mem_wr_tag`/`mem_wr_line`, holds it until `mem_wr_done`, and drains entries in eviction order.
- R9: A miss whose victim is dirty while the queue is full stalls with no response until an entry drains, then completes normally.
- R10: A miss whose tag matches a pending queue entry takes the newest matching line from the queue without a memory read.
- R11: `hit_count` and `miss_count` each add one per accepted request that hits or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 8 | Store byte |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | 8 | Loaded byte (stored byte for stores) |
| mem_rd_req | output | 1 | Line fetch request |
| mem_rd_tag | output | 4 | Tag of line to fetch |
| mem_rd_valid | input | 1 | Fetched line present |
| mem_rd_line | input | 16 | Fetched line |
| mem_wr_req | output | 1 | Queue head awaits write |
| mem_wr_tag | output | 4 | Tag of queued line |
| mem_wr_line | output | 16 | Queued line data |
| mem_wr_done | input | 1 | Memory finished the head write |
| hit_count | output | 16 | Hit counter |
| miss_count | output | 16 | Miss counter |

## Verification
The bench uses the default geometry: two lines of two bytes, 5-bit addresses and a two-entry eviction queue. With only two ways, the victim of each miss follows directly from the access order, so the LRU choice and the clean/dirty split can be predicted exactly. Two dirty evictions are enough to fill the queue. With memory writes held off, the bench reaches the full-queue stall and the queue forwarding path, and then checks the drain order and the whole-line data that memory receives.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_FILL = 2'd2
  } wbc_state_e;
endpackage

// File: rtl/wbc_lines.sv
module wbc_lines #(
  parameter int NLINES = 2,
  parameter int TAG_W  = 4,
  parameter int LINE_W = 16,
  parameter int WAY_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [LINE_W-1:0] lk_line,
  output logic [WAY_W-1:0]  vic_way,
  output logic              vic_valid,
  output logic              vic_dirty,
  output logic [TAG_W-1:0]  vic_tag,
  output logic [LINE_W-1:0] vic_line,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty,
  input  logic              touch_en,
  input  logic [WAY_W-1:0]  touch_way
);
  logic [NLINES-1:0]             valid_q, dirty_q;
  logic [TAG_W-1:0]              tag_q  [NLINES];
  logic [LINE_W-1:0]             line_q [NLINES];
  logic [NLINES-1:0][NLINES-1:0] newer_q;
  logic [NLINES-1:0]             match, is_lru;

  for (genvar g = 0; g < NLINES; g++) begin : g_cmp
    assign match[g]  = valid_q[g] && (tag_q[g] == lk_tag);
    assign is_lru[g] = (newer_q[g] == '0);
  end

  always_comb begin
    lk_hit    = 1'b0;
    lk_way    = '0;
    vic_way   = '0;
    vic_valid = 1'b1;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit = 1'b1;
        lk_way = WAY_W'(i);
      end
      if (is_lru[i] && vic_valid) vic_way = WAY_W'(i);
    end
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        vic_way   = WAY_W'(i);
        vic_valid = 1'b0;
      end
    end
    lk_line   = line_q[lk_way];
    vic_dirty = dirty_q[vic_way];
    vic_tag   = tag_q[vic_way];
    vic_line  = line_q[vic_way];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      newer_q <= '0;
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (wr_en && (wr_way == WAY_W'(i))) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= wr_dirty;
        end
        if (touch_en) begin
          if (touch_way == WAY_W'(i)) newer_q[i] <= ~(NLINES'(1) << i);
          else                        newer_q[i][touch_way] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NLINES; i++) begin
      if (wr_en && (wr_way == WAY_W'(i))) begin
        tag_q[i]  <= wr_tag;
        line_q[i] <= wr_line;
      end
    end
  end
endmodule

// File: rtl/wbc_evq.sv
module wbc_evq #(
  parameter int DEPTH  = 2,
  parameter int TAG_W  = 4,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [LINE_W-1:0] push_line,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic [TAG_W-1:0]  head_tag,
  output logic [LINE_W-1:0] head_line,
  input  logic [TAG_W-1:0]  srch_tag,
  output logic              srch_hit,
  output logic [LINE_W-1:0] srch_line
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = (int'(cnt_q) == DEPTH);
  assign empty     = (cnt_q == '0);
  assign head_tag  = tag_q[rd_q];
  assign head_line = line_q[rd_q];

  always_comb begin
    srch_hit  = 1'b0;
    srch_line = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(rd_q) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if ((k < int'(cnt_q)) && (tag_q[idx] == srch_tag)) begin
        srch_hit  = 1'b1;
        srch_line = line_q[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop && !empty) rd_q <= bump(rd_q);
      if (push && !(pop && !empty))      cnt_q <= cnt_q + CNT_W'(1);
      else if (!push && (pop && !empty)) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      tag_q[wr_q]  <= push_tag;
      line_q[wr_q] <= push_line;
    end
  end
endmodule

// File: rtl/wbc_top.sv
module wbc_top
  import wbc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int OFF_W     = 1,
  parameter int NLINES    = 2,
  parameter int EVQ_DEPTH = 2,
  parameter int CNT_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [7:0]                req_wdata,
  output logic                      req_ready,
  output logic                      resp_valid,
  output logic                      resp_hit,
  output logic [7:0]                resp_rdata,
  output logic                      mem_rd_req,
  output logic [ADDR_W-OFF_W-1:0]   mem_rd_tag,
  input  logic                      mem_rd_valid,
  input  logic [8*(1<<OFF_W)-1:0]   mem_rd_line,
  output logic                      mem_wr_req,
  output logic [ADDR_W-OFF_W-1:0]   mem_wr_tag,
  output logic [8*(1<<OFF_W)-1:0]   mem_wr_line,
  input  logic                      mem_wr_done,
  output logic [CNT_W-1:0]          hit_count,
  output logic [CNT_W-1:0]          miss_count
);
  localparam int LINE_W = 8 * (1 << OFF_W);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int WAY_W  = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wbc_state_e        state_q, state_d;
  logic              op_write_q;
  logic [TAG_W-1:0]  op_tag_q;
  logic [OFF_W-1:0]  op_off_q;
  logic [7:0]        op_wdata_q;
  logic [WAY_W-1:0]  vic_way_q;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;

  logic              lk_hit, vic_valid, vic_dirty;
  logic [WAY_W-1:0]  lk_way, vic_way, wr_way;
  logic [LINE_W-1:0] lk_line, vic_line, fill_line, base_line, new_line;
  logic [TAG_W-1:0]  vic_tag, wr_tag;
  logic              wr_en, touch_en;
  logic              q_push, q_pop, q_full, q_empty, q_hit;
  logic [LINE_W-1:0] q_line;
  logic              accept, hit_acc, miss_go, fwd, fill_done;
  logic              cur_write;
  logic [OFF_W-1:0]  cur_off;
  logic [7:0]        cur_wdata;

  function automatic logic [LINE_W-1:0] put_byte(input logic [LINE_W-1:0] line,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [7:0] b);
    logic [LINE_W-1:0] r;
    r = line;
    r[off*8 +: 8] = b;
    return r;
  endfunction

  assign req_tag = req_addr[ADDR_W-1:OFF_W];
  assign req_off = req_addr[OFF_W-1:0];

  wbc_lines #(.NLINES(NLINES), .TAG_W(TAG_W), .LINE_W(LINE_W), .WAY_W(WAY_W)) u_lines (
    .clk(clk), .rst_n(rst_n_int),
    .lk_tag(req_tag), .lk_hit(lk_hit), .lk_way(lk_way), .lk_line(lk_line),
    .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_tag(vic_tag), .vic_line(vic_line),
    .wr_en(wr_en), .wr_way(wr_way), .wr_tag(wr_tag), .wr_line(new_line),
    .wr_dirty(cur_write), .touch_en(touch_en), .touch_way(wr_way)
  );

  wbc_evq #(.DEPTH(EVQ_DEPTH), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_evq (
    .clk(clk), .rst_n(rst_n_int),
    .push(q_push), .push_tag(vic_tag), .push_line(vic_line),
    .pop(q_pop), .full(q_full), .empty(q_empty),
    .head_tag(mem_wr_tag), .head_line(mem_wr_line),
    .srch_tag(op_tag_q), .srch_hit(q_hit), .srch_line(q_line)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign hit_acc    = accept && lk_hit;
  assign miss_go    = (state_q == ST_MISS) && !(vic_valid && vic_dirty && q_full);
  assign q_push     = miss_go && vic_valid && vic_dirty;
  assign fwd        = miss_go && q_hit;
  assign fill_done  = fwd || ((state_q == ST_FILL) && mem_rd_valid);
  assign fill_line  = fwd ? q_line : mem_rd_line;
  assign q_pop      = mem_wr_done && !q_empty;
  assign mem_wr_req = !q_empty;
  assign mem_rd_req = (state_q == ST_FILL);
  assign mem_rd_tag = op_tag_q;

  always_comb begin
    cur_write = hit_acc ? req_write : op_write_q;
    cur_off   = hit_acc ? req_off   : op_off_q;
    cur_wdata = hit_acc ? req_wdata : op_wdata_q;
    base_line = hit_acc ? lk_line   : fill_line;
    new_line  = cur_write ? put_byte(base_line, cur_off, cur_wdata) : base_line;
    wr_en     = (hit_acc && req_write) || fill_done;
    touch_en  = hit_acc || fill_done;
    wr_tag    = hit_acc ? req_tag : op_tag_q;
    wr_way    = hit_acc ? lk_way : (fwd ? vic_way : vic_way_q);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept && !lk_hit) state_d = ST_MISS;
      ST_MISS: if (miss_go) state_d = fwd ? ST_IDLE : ST_FILL;
      ST_FILL: if (mem_rd_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q    <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      op_write_q <= 1'b0;
      op_tag_q   <= '0;
      op_off_q   <= '0;
      op_wdata_q <= '0;
      vic_way_q  <= '0;
    end else begin
      state_q    <= state_d;
      resp_valid <= hit_acc || fill_done;
      if (hit_acc || fill_done) begin
        resp_hit   <= hit_acc;
        resp_rdata <= new_line[cur_off*8 +: 8];
      end
      if (hit_acc) hit_count <= hit_count + CNT_W'(1);
      if (accept && !lk_hit) begin
        miss_count <= miss_count + CNT_W'(1);
        op_write_q <= req_write;
        op_tag_q   <= req_tag;
        op_off_q   <= req_off;
        op_wdata_q <= req_wdata;
      end
      if (miss_go) vic_way_q <= vic_way;
    end
  end
endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
  parameter int TAG_W  = 4,
  parameter int LINE_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [TAG_W-1:0]  mem_rd_tag,
  input logic              mem_wr_req,
  input logic              mem_wr_done,
  input logic [TAG_W-1:0]  mem_wr_tag,
  input logic [LINE_W-1:0] mem_wr_line,
  input logic              q_push,
  input logic              q_full,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_tag))); // R2

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_done) |=> (mem_wr_req && $stable(mem_wr_tag) && $stable(mem_wr_line))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> !q_full); // R9

  AST_HIT_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> (hit_count == $past(hit_count) + CNT_W'(1))); // R11

  AST_MISS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> !req_ready); // R11
endmodule

bind wbc_top wbc_chk #(.TAG_W(TAG_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) i_wbc_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
  .mem_rd_tag(mem_rd_tag), .mem_wr_req(mem_wr_req), .mem_wr_done(mem_wr_done),
  .mem_wr_tag(mem_wr_tag), .mem_wr_line(mem_wr_line), .q_push(q_push),
  .q_full(q_full), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/test_wbc_top.sv
module test_wbc_top;
  localparam int TAG_W  = 4;
  localparam int LINE_W = 16;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, req_valid, req_write, req_ready;
  logic [4:0]        req_addr;
  logic [7:0]        req_wdata, resp_rdata;
  logic              resp_valid, resp_hit;
  logic              mem_rd_req, mem_rd_valid, mem_wr_req, mem_wr_done;
  logic [TAG_W-1:0]  mem_rd_tag, mem_wr_tag;
  logic [LINE_W-1:0] mem_rd_line, mem_wr_line;
  logic [CNT_W-1:0]  hit_count, miss_count;

  wbc_top i_wbc_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_tag(mem_rd_tag), .mem_rd_valid(mem_rd_valid),
    .mem_rd_line(mem_rd_line), .mem_wr_req(mem_wr_req), .mem_wr_tag(mem_wr_tag),
    .mem_wr_line(mem_wr_line), .mem_wr_done(mem_wr_done),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  logic [LINE_W-1:0] mem [16];
  logic [TAG_W-1:0]  wlog_tag  [16];
  logic [LINE_W-1:0] wlog_line [16];
  int  n_checks = 0, n_fail = 0, n_reads = 0, n_writes = 0, rd_cnt = 0;
  bit  wr_allow = 1'b1;
  bit  finished = 1'b0;

  function automatic logic [7:0] init_b(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  // memory model: fixed read latency, writes complete when allowed
  initial begin
    mem_rd_valid = 1'b0;
    mem_rd_line  = '0;
    mem_wr_done  = 1'b0;
    for (int t = 0; t < 16; t++) mem[t] = {init_b(2*t + 1), init_b(2*t)};
    forever begin
      @(negedge clk);
      if (mem_rd_valid) mem_rd_valid = 1'b0;
      else if (mem_rd_req) begin
        if (rd_cnt == 2) begin
          mem_rd_valid = 1'b1;
          mem_rd_line  = mem[mem_rd_tag];
          rd_cnt = 0;
          n_reads++;
        end else rd_cnt++;
      end
      if (mem_wr_req && wr_allow) begin
        mem[mem_wr_tag] = mem_wr_line;
        if (n_writes < 16) begin
          wlog_tag[n_writes]  = mem_wr_tag;
          wlog_line[n_writes] = mem_wr_line;
        end
        n_writes++;
        mem_wr_done = 1'b1;
      end else mem_wr_done = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input bit w, input int addr, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = 5'(addr);
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic await_resp(input int max, output bit got, output logic [7:0] d,
                            output logic h);
    got = 1'b0; d = '0; h = 1'b0;
    for (int i = 0; i < max; i++) begin
      if (resp_valid) begin
        got = 1'b1; d = resp_rdata; h = resp_hit;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic access(input bit w, input int addr, input logic [7:0] wd,
                        input logic [7:0] exp_d, input bit exp_hit, input string req);
    bit got; logic [7:0] d; logic h;
    send(w, addr, wd);
    await_resp(100, got, d, h);
    check(req, 32'(got), 32'd1, "response seen");
    if (got) begin
      check(req, 32'(d), 32'(exp_d), "data");
      check(req, 32'(h), 32'(exp_hit), "hit flag");
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 100; i++) begin
      if (!mem_wr_req) return;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1", 32'(req_ready), 1, "ready");
    check("R1", 32'(resp_valid), 0, "resp_valid");
    check("R1", 32'(mem_rd_req), 0, "mem_rd_req");
    check("R1", 32'(mem_wr_req), 0, "mem_wr_req");
    check("R1", 32'(hit_count), 0, "hit_count");
    check("R1", 32'(miss_count), 0, "miss_count");
  endtask

  task automatic t_load_fill();
    access(0, 1, 8'h00, init_b(1), 0, "R2");
    access(0, 0, 8'h00, init_b(0), 1, "R3");
    check("R2", n_reads, 1, "line fetches");
  endtask

  task automatic t_store_hit();
    access(1, 0, 8'h11, 8'h11, 1, "R4");
    repeat (4) @(negedge clk);
    check("R4", n_writes, 0, "memory writes after store hit");
    check("R4", 32'(mem_wr_req), 0, "mem_wr_req after store hit");
    access(0, 0, 8'h00, 8'h11, 1, "R4");
  endtask

  task automatic t_evict();
    access(0, 2, 8'h00, init_b(2), 0, "R6");           // fills the empty line
    access(0, 1, 8'h00, init_b(1), 1, "R6");           // tag 0 kept, now most recent
    access(0, 4, 8'h00, init_b(4), 0, "R7");           // LRU victim is clean tag 1
    repeat (4) @(negedge clk);
    check("R7", n_writes, 0, "memory writes after clean eviction");
    access(0, 2, 8'h00, init_b(2), 0, "R6");           // tag 1 gone; dirty tag 0 evicted
    drain();
    check("R8", n_writes, 1, "write count");
    check("R8", 32'(wlog_tag[0]), 0, "write tag");
    check("R8", 32'(wlog_line[0]), 32'h0000A411, "whole line written");
  endtask

  task automatic t_queue();
    bit got; logic [7:0] d; logic h; int rd_snap;
    wr_allow = 1'b0;
    access(1, 2, 8'h22, 8'h22, 1, "R4");
    access(1, 4, 8'h33, 8'h33, 1, "R4");
    access(0, 8, 8'h00, init_b(8), 0, "R8");           // dirty tag 1 queued
    rd_snap = n_reads;
    access(0, 2, 8'h00, 8'h22, 0, "R10");              // tag 2 queued, tag 1 forwarded
    check("R10", n_reads, rd_snap, "no memory fetch on queue match");
    access(1, 8, 8'h55, 8'h55, 1, "R4");
    access(1, 3, 8'h66, 8'h66, 1, "R4");
    send(0, 10, 8'h00);                                 // dirty victim, queue full
    await_resp(20, got, d, h);
    check("R9", 32'(got), 0, "no response while queue full");
    check("R9", 32'(mem_wr_req), 1, "queue offers head");
    wr_allow = 1'b1;
    await_resp(100, got, d, h);
    check("R9", 32'(got), 1, "response after drain");
    check("R9", 32'(d), 32'(init_b(10)), "data after stall");
    drain();
    check("R8", n_writes, 4, "write count after drain");
    check("R8", 32'(wlog_tag[1]), 1, "first queued tag");
    check("R8", 32'(wlog_line[1]), 32'h0000A622, "first queued line");
    check("R8", 32'(wlog_tag[2]), 2, "second queued tag");
    check("R8", 32'(wlog_line[2]), 32'h0000A033, "second queued line");
    check("R8", 32'(wlog_tag[3]), 4, "third queued tag");
    check("R8", 32'(wlog_line[3]), 32'h0000AC55, "third queued line");
  endtask

  task automatic t_store_miss();
    access(1, 5, 8'h77, 8'h77, 0, "R5");
    drain();
    check("R8", n_writes, 5, "write count");
    check("R8", 32'(wlog_line[4]), 32'h00006622, "dirty tag 1 line");
    access(0, 4, 8'h00, 8'h33, 1, "R5");
    access(0, 5, 8'h00, 8'h77, 1, "R5");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_fill();
    t_store_hit();
    t_evict();
    t_queue();
    t_store_miss();
    check("R11", 32'(hit_count), 10, "hit_count");
    check("R11", 32'(miss_count), 8, "miss_count");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule